// File: doc/BRIEF.md
# SCSI Controller Command Dispatcher

This block sits behind the command register of a SCSI protocol controller. Each byte the host writes there is decoded and checked against the controller's current connection state: disconnected, connected as initiator, or connected as target. A command that fits the state is launched toward the bus sequencer as a one-cycle pulse, with its 7-bit opcode and DMA flag. A command that does not fit is refused and flagged in the interrupt status register.

The block owns the interrupt status register, the interrupt-pending flag and the connection state. Commands that run on the sequencer (selection, information transfer and the like) mark the dispatcher busy. The sequencer's completion is stubbed here as a `done_i` strobe that carries interrupt bits and the new connection state. A few commands finish at once and never interrupt. The host clears pending interrupts by reading the status register.

Top module: `scsi_cmd_dispatch`

## Requirements
- R1: Opcodes 0x00 (no-op), 0x01 (flush), 0x02 (controller reset) and 0x03 (bus reset) are accepted in every connection state.
- R2: Opcodes 0x40 to 0x46 are accepted only while `conn_state_o` is 0 (disconnected).
- R3: Opcodes 0x10, 0x11, 0x12, 0x18, 0x1A and 0x1B are accepted only while `conn_state_o` is 1 (initiator).
- R4: Opcode 0x27 is accepted only while `conn_state_o` is 2 (target). Once accepted, it moves the state to 0 on the next edge and raises no interrupt.
- R5: Bit 7 of the command byte has no effect on legality. On the edge of an accepted write, `launch_o` goes high for one cycle, with `launch_cmd_o` set to bits 6:0 and `launch_dma_o` set to bit 7.
- R6: Any other opcode, or an opcode written in the wrong state, is illegal. On the next edge it sets `isr_o[6]`, leaves the connection state unchanged and produces no launch, so `irq_o` is high.
- R7: Accepted opcodes 0x00, 0x01, 0x02, 0x44, 0x1A, 0x1B and 0x27 leave `isr_o` unchanged (0x02 clears it).
- R8: Opcodes 0x40–0x43, 0x45, 0x46, 0x10–0x12 and 0x18 mark the block busy. A `done_i` strobe while busy ORs `done_int_i` into `isr_o`, loads `done_state_i` (the value 3 maps to 0) and clears busy. A `done_i` strobe while idle is ignored.
- R9: An accepted 0x03 returns the state to 0 and clears busy. It sets `isr_o[7]` unless `cfg_rst_int_dis_i` is high.
- R10: While `isr_re_i` is high, `isr_o` shows the current bits. On the next edge the register clears, except for bits that are set in that same cycle.
- R11: `status_o[7]` and `irq_o` are high whenever `isr_o` is nonzero. `status_o[2:0]` follows `phase_i` (MSG, CD, IO). `status_o[6:3]` is 0.
- R12: An accepted 0x02 clears `isr_o`, busy and the connection state on the next edge, overriding any bit set in that cycle.
- R13: After reset, `isr_o` is 0, `conn_state_o` is 0, the block is not busy and `launch_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_i | input | 8 | Command byte; bit 7 selects the DMA variant |
| cfg_rst_int_dis_i | input | 1 | Masks the bus-reset interrupt |
| isr_re_i | input | 1 | Interrupt status read strobe |
| done_i | input | 1 | Sequencer completion strobe |
| done_int_i | input | 8 | Interrupt bits reported at completion |
| done_state_i | input | 2 | Connection state after completion |
| phase_i | input | 3 | Bus phase {MSG,CD,IO} |
| isr_o | output | 8 | Interrupt status register |
| status_o | output | 8 | Status: pending flag and bus phase |
| irq_o | output | 1 | Interrupt request |
| conn_state_o | output | 2 | 0 disconnected, 1 initiator, 2 target |
| launch_o | output | 1 | One-cycle launch pulse |
| launch_cmd_o | output | 7 | Launched opcode |
| launch_dma_o | output | 1 | Launched command uses DMA |

## Verification
The assertions check, on every cycle, the properties that can be tied to a single edge:
- an out-of-state disconnect being flagged;
- the launch echo of opcode and DMA bit;
- read-to-clear;
- the override by a controller reset;
- the masked bus reset;
- the quiet initiator commands;
- a completion strobe while idle being ignored.

The complete legality matrix of opcodes against the three states can only be shown by the bench's scenarios. The same holds for the sequence that brings the block into initiator or target state through a completion, and for a status read that coincides with a new interrupt.

// File: rtl/scsi_dispatch_pkg.sv
package scsi_dispatch_pkg;
  localparam int unsigned CMD_W = 8;
  localparam int unsigned OP_W  = CMD_W - 1;
  localparam int unsigned ISR_W = 8;
  localparam int unsigned PH_W  = 3;

  typedef enum logic [1:0] {
    CONN_IDLE = 2'd0,
    CONN_INIT = 2'd1,
    CONN_TGT  = 2'd2
  } conn_e;

  localparam logic [ISR_W-1:0] ISR_BUS_RST = 8'h80;
  localparam logic [ISR_W-1:0] ISR_ILLEGAL = 8'h40;

  localparam logic [OP_W-1:0] OP_SOFT_RST = 7'h02;
  localparam logic [OP_W-1:0] OP_BUS_RST  = 7'h03;
  localparam logic [OP_W-1:0] OP_DISC     = 7'h27;
endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
  import scsi_dispatch_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  conn_e           conn_i,
  output logic            legal_o,
  output logic            waits_o,
  output logic            soft_rst_o,
  output logic            bus_rst_o,
  output logic            to_idle_o
);
  logic any_ok, disc_ok, init_ok, tgt_ok, quiet;

  always_comb begin
    any_ok  = (op_i <= 7'h03);
    disc_ok = (op_i >= 7'h40) && (op_i <= 7'h46);
    init_ok = (op_i inside {7'h10, 7'h11, 7'h12, 7'h18, 7'h1a, 7'h1b});
    tgt_ok  = (op_i == OP_DISC);
    quiet   = (op_i inside {7'h00, 7'h01, 7'h02, 7'h03, 7'h44, 7'h1a, 7'h1b, 7'h27});
    legal_o = any_ok
            | (disc_ok & (conn_i == CONN_IDLE))
            | (init_ok & (conn_i == CONN_INIT))
            | (tgt_ok  & (conn_i == CONN_TGT));
    waits_o    = legal_o & ~quiet;
    soft_rst_o = (op_i == OP_SOFT_RST);
    bus_rst_o  = (op_i == OP_BUS_RST);
    to_idle_o  = legal_o & ((op_i == OP_DISC) | (op_i == OP_BUS_RST));
  end
endmodule

// File: rtl/scsi_conn_track.sv
module scsi_conn_track
  import scsi_dispatch_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wipe_i,
  input  logic       accept_i,
  input  logic       waits_i,
  input  logic       to_idle_i,
  input  logic       done_i,
  input  logic [1:0] done_state_i,
  output conn_e      conn_o,
  output logic       busy_o,
  output logic       done_take_o
);
  conn_e conn_q, done_conn;
  logic  busy_q;

  assign done_take_o = done_i & busy_q & ~wipe_i;
  assign done_conn   = (done_state_i == 2'd3) ? CONN_IDLE : conn_e'(done_state_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conn_q <= CONN_IDLE;
      busy_q <= 1'b0;
    end else if (wipe_i) begin
      conn_q <= CONN_IDLE;
      busy_q <= 1'b0;
    end else begin
      if (accept_i && to_idle_i)  conn_q <= CONN_IDLE;
      else if (done_take_o)       conn_q <= done_conn;
      if (accept_i && (waits_i || to_idle_i)) busy_q <= waits_i;
      else if (done_take_o)                   busy_q <= 1'b0;
    end
  end

  assign conn_o = conn_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/scsi_isr_reg.sv
module scsi_isr_reg
  import scsi_dispatch_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wipe_i,
  input  logic             rd_clr_i,
  input  logic [ISR_W-1:0] set_i,
  output logic [ISR_W-1:0] isr_o
);
  logic [ISR_W-1:0] isr_q;

  // bits set in the read cycle survive the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       isr_q <= '0;
    else if (wipe_i)   isr_q <= '0;
    else               isr_q <= (rd_clr_i ? '0 : isr_q) | set_i;
  end

  assign isr_o = isr_q;
endmodule

// File: rtl/scsi_cmd_dispatch.sv
module scsi_cmd_dispatch
  import scsi_dispatch_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             cfg_rst_int_dis_i,
  input  logic             isr_re_i,
  input  logic             done_i,
  input  logic [ISR_W-1:0] done_int_i,
  input  logic [1:0]       done_state_i,
  input  logic [PH_W-1:0]  phase_i,
  output logic [ISR_W-1:0] isr_o,
  output logic [7:0]       status_o,
  output logic             irq_o,
  output logic [1:0]       conn_state_o,
  output logic             launch_o,
  output logic [OP_W-1:0]  launch_cmd_o,
  output logic             launch_dma_o
);
  conn_e            conn;
  logic             legal, waits, soft_rst, bus_rst, to_idle;
  logic             accept, wipe, busy_q, done_take;
  logic [ISR_W-1:0] set_bits, isr_q;
  logic             launch_q, dma_q;
  logic [OP_W-1:0]  op_q;

  scsi_cmd_decode u_dec (
    .op_i      (cmd_i[OP_W-1:0]),
    .conn_i    (conn),
    .legal_o   (legal),
    .waits_o   (waits),
    .soft_rst_o(soft_rst),
    .bus_rst_o (bus_rst),
    .to_idle_o (to_idle)
  );

  assign accept = cmd_we_i & legal;
  assign wipe   = accept & soft_rst;

  scsi_conn_track u_conn (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wipe_i      (wipe),
    .accept_i    (accept),
    .waits_i     (waits),
    .to_idle_i   (to_idle),
    .done_i      (done_i),
    .done_state_i(done_state_i),
    .conn_o      (conn),
    .busy_o      (busy_q),
    .done_take_o (done_take)
  );

  always_comb begin
    set_bits = '0;
    if (cmd_we_i && !legal)                         set_bits |= ISR_ILLEGAL;
    if (accept && bus_rst && !cfg_rst_int_dis_i)    set_bits |= ISR_BUS_RST;
    if (done_take)                                  set_bits |= done_int_i;
  end

  scsi_isr_reg u_isr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wipe_i  (wipe),
    .rd_clr_i(isr_re_i),
    .set_i   (set_bits),
    .isr_o   (isr_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      launch_q <= 1'b0;
      op_q     <= '0;
      dma_q    <= 1'b0;
    end else begin
      launch_q <= accept;
      if (accept) begin
        op_q  <= cmd_i[OP_W-1:0];
        dma_q <= cmd_i[CMD_W-1];
      end
    end
  end

  assign isr_o        = isr_q;
  assign irq_o        = |isr_q;
  assign status_o     = {irq_o, 4'b0000, phase_i};
  assign conn_state_o = conn;
  assign launch_o     = launch_q;
  assign launch_cmd_o = op_q;
  assign launch_dma_o = dma_q;
endmodule

module scsi_cmd_dispatch_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_we_i,
  input logic [7:0] cmd_i,
  input logic       cfg_rst_int_dis_i,
  input logic       isr_re_i,
  input logic       done_i,
  input logic [7:0] isr_o,
  input logic [1:0] conn_state_o,
  input logic       launch_o,
  input logic [6:0] launch_cmd_o,
  input logic       launch_dma_o,
  input logic       busy_q
);
  a_r6_bad_disconnect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && cmd_i[6:0] == 7'h27 && conn_state_o != 2'd2 && !done_i
    |=> isr_o[6] && $stable(conn_state_o));

  a_r4_disconnect_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && cmd_i[6:0] == 7'h27 && conn_state_o == 2'd2 |=> conn_state_o == 2'd0);

  a_r5_launch_echo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> launch_cmd_o == $past(cmd_i[6:0]) && launch_dma_o == $past(cmd_i[7]));

  a_r10_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_re_i && !cmd_we_i && !done_i |=> isr_o == 8'h00);

  a_r12_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && cmd_i[6:0] == 7'h02 |=> isr_o == 8'h00 && conn_state_o == 2'd0 && !busy_q);

  a_r9_masked_bus_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && cmd_i[6:0] == 7'h03 && cfg_rst_int_dis_i && !done_i && isr_o == 8'h00
    |=> isr_o == 8'h00 && conn_state_o == 2'd0);

  a_r7_quiet_atn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && cmd_i[6:0] == 7'h1b && conn_state_o == 2'd1 && !done_i && isr_o == 8'h00
    |=> isr_o == 8'h00);

  a_r8_idle_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !busy_q && !cmd_we_i && !isr_re_i |=> $stable(isr_o));
endmodule

bind scsi_cmd_dispatch scsi_cmd_dispatch_chk u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .cmd_we_i         (cmd_we_i),
  .cmd_i            (cmd_i),
  .cfg_rst_int_dis_i(cfg_rst_int_dis_i),
  .isr_re_i         (isr_re_i),
  .done_i           (done_i),
  .isr_o            (isr_o),
  .conn_state_o     (conn_state_o),
  .launch_o         (launch_o),
  .launch_cmd_o     (launch_cmd_o),
  .launch_dma_o     (launch_dma_o),
  .busy_q           (busy_q)
);

// File: tb/scsi_cmd_dispatch_test.sv
module scsi_cmd_dispatch_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd = '0;
  logic       cfg_dis = 1'b0;
  logic       isr_re = 1'b0;
  logic       done = 1'b0;
  logic [7:0] done_int = '0;
  logic [1:0] done_state = '0;
  logic [2:0] phase = '0;
  logic [7:0] isr, status;
  logic       irq, launch, ldma;
  logic [1:0] conn;
  logic [6:0] lcmd;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  scsi_cmd_dispatch uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_i(cmd),
    .cfg_rst_int_dis_i(cfg_dis), .isr_re_i(isr_re), .done_i(done),
    .done_int_i(done_int), .done_state_i(done_state), .phase_i(phase),
    .isr_o(isr), .status_o(status), .irq_o(irq), .conn_state_o(conn),
    .launch_o(launch), .launch_cmd_o(lcmd), .launch_dma_o(ldma)
  );

  // {start state, cmd, expected isr, expected launch, expected end state, requirement}
  typedef struct packed {
    logic [1:0] st;
    logic [7:0] cmd;
    logic [7:0] isr;
    logic       lau;
    logic [1:0] conn;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'h00, 8'h00, 1'b1, 2'd0, 4'd1},   // R1
    '{2'd0, 8'h41, 8'h00, 1'b1, 2'd0, 4'd2},   // R2
    '{2'd0, 8'hc2, 8'h00, 1'b1, 2'd0, 4'd5},   // R5
    '{2'd0, 8'h44, 8'h00, 1'b1, 2'd0, 4'd7},   // R7
    '{2'd0, 8'h10, 8'h40, 1'b0, 2'd0, 4'd3},   // R3
    '{2'd0, 8'h27, 8'h40, 1'b0, 2'd0, 4'd4},   // R4
    '{2'd1, 8'h1a, 8'h00, 1'b1, 2'd1, 4'd3},   // R3
    '{2'd1, 8'h9b, 8'h00, 1'b1, 2'd1, 4'd5},   // R5
    '{2'd1, 8'h11, 8'h00, 1'b1, 2'd1, 4'd3},   // R3
    '{2'd1, 8'h42, 8'h40, 1'b0, 2'd1, 4'd2},   // R2
    '{2'd1, 8'h27, 8'h40, 1'b0, 2'd1, 4'd4},   // R4
    '{2'd1, 8'h01, 8'h00, 1'b1, 2'd1, 4'd1},   // R1
    '{2'd2, 8'h27, 8'h00, 1'b1, 2'd0, 4'd4},   // R4
    '{2'd2, 8'h10, 8'h40, 1'b0, 2'd2, 4'd3},   // R3
    '{2'd2, 8'h46, 8'h40, 1'b0, 2'd2, 4'd2},   // R2
    '{2'd2, 8'h47, 8'h40, 1'b0, 2'd2, 4'd6},   // R6
    '{2'd0, 8'h03, 8'h80, 1'b1, 2'd0, 4'd9},   // R9
    '{2'd1, 8'h03, 8'h80, 1'b1, 2'd0, 4'd9},   // R9
    '{2'd2, 8'h02, 8'h00, 1'b1, 2'd0, 4'd12},  // R12
    '{2'd1, 8'h80, 8'h00, 1'b1, 2'd1, 4'd5}    // R5
  };

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic write_cmd(input logic [7:0] c);
    @(negedge clk); cmd_we = 1'b1; cmd = c;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic complete(input logic [1:0] st, input logic [7:0] bits);
    @(negedge clk); done = 1'b1; done_state = st; done_int = bits;
    @(negedge clk); done = 1'b0; done_int = '0;
  endtask

  task automatic read_isr();
    @(negedge clk); isr_re = 1'b1;
    @(negedge clk); isr_re = 1'b0;
  endtask

  task automatic enter_state(input logic [1:0] st);
    write_cmd(8'h02);
    if (st != 2'd0) begin
      write_cmd(8'h41);
      complete(st, 8'h18);
      read_isr();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 isr", isr, 0);
    chk("R13 conn", conn, 0);
    chk("R13 launch", launch, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      enter_state(VECS[i].st);
      @(negedge clk); cmd_we = 1'b1; cmd = VECS[i].cmd;
      @(negedge clk); cmd_we = 1'b0;
      chk($sformatf("R%0d isr v%0d", VECS[i].req, i), isr, VECS[i].isr);
      chk($sformatf("R%0d launch v%0d", VECS[i].req, i), launch, VECS[i].lau);
      chk($sformatf("R%0d conn v%0d", VECS[i].req, i), conn, VECS[i].conn);
      if (VECS[i].lau) begin
        chk($sformatf("R%0d opcode v%0d", VECS[i].req, i), lcmd, VECS[i].cmd[6:0]);
        chk($sformatf("R%0d dma v%0d", VECS[i].req, i), ldma, VECS[i].cmd[7]);
      end
      @(negedge clk);
      chk($sformatf("R%0d pulse v%0d", VECS[i].req, i), launch, 0);
    end

    // R6 illegal drives irq and pending
    enter_state(2'd0);
    write_cmd(8'h1a);
    chk("R6 irq", irq, 1);
    chk("R11 pending", status[7], 1);

    // R10 read shows value, clears next edge
    @(negedge clk); isr_re = 1'b1;
    chk("R10 read value", isr, 8'h40);
    @(negedge clk); isr_re = 1'b0;
    chk("R10 cleared", isr, 0);
    chk("R11 irq low", irq, 0);

    // R8 done while idle ignored
    complete(2'd1, 8'h10);
    chk("R8 idle done isr", isr, 0);
    chk("R8 idle done conn", conn, 0);

    // R10 bit arriving in read cycle survives
    write_cmd(8'h40);
    write_cmd(8'h27);               // illegal in idle, sets 0x40
    @(negedge clk); isr_re = 1'b1; done = 1'b1; done_int = 8'h04; done_state = 2'd1;
    @(negedge clk); isr_re = 1'b0; done = 1'b0; done_int = '0;
    chk("R10 same-cycle bit", isr, 8'h04);
    chk("R8 done loads state", conn, 1);
    complete(2'd2, 8'h08);          // no longer busy
    chk("R8 second done ignored", isr, 8'h04);

    // R9 masked bus reset
    read_isr();
    cfg_dis = 1'b1;
    write_cmd(8'h83);
    chk("R9 masked isr", isr, 0);
    chk("R9 masked conn", conn, 0);
    cfg_dis = 1'b0;

    // R12 controller reset overrides same-cycle set and busy
    write_cmd(8'h45);
    @(negedge clk); cmd_we = 1'b1; cmd = 8'h02; done = 1'b1; done_int = 8'h20;
    @(negedge clk); cmd_we = 1'b0; done = 1'b0; done_int = '0;
    chk("R12 isr wiped", isr, 0);
    complete(2'd1, 8'h08);
    chk("R12 busy cleared", isr, 0);

    // R11 phase and reserved bits
    phase = 3'b110;
    @(negedge clk);
    chk("R11 status msg-out", status, 8'h06);
    phase = 3'b011;
    write_cmd(8'h7f);
    chk("R11 status pending", status, 8'h83);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule